// File: doc/BRIEF.md
# Accumulator-Quotient Shift Unit

This block holds a pair of 16-bit registers, an accumulator and a quotient register, and shifts them by a count from 0 to 15. It has four operations. Two are single-register shifts of the accumulator: a logical shift toward the MSB and an arithmetic shift toward the LSB. The other two treat the pair as one 32-bit value with the accumulator as the upper half, and shift that value left logically or right arithmetically.

Software-visible sequencing is minimal. A load strobe writes both registers from input ports. A start strobe samples the operation code and the count. A one-cycle done pulse marks the point where the result can be read on the two read-back ports.

A parameter selects the implementation. One variant shifts one bit per clock. The other uses a staged barrel shifter and finishes in one cycle. Both variants produce identical register contents.

Top module: `acq_shift_unit`

## Requirements
- R1: A synchronous active-high reset clears the accumulator, the quotient register and done to zero.
- R2: When idle, load writes `load_acc` into the accumulator and `load_quo` into the quotient register. If load and start are both high in the same cycle, load is taken and start is ignored. A load during an operation is ignored.
- R3: Operation code 00 (single left): the accumulator moves toward its MSB by N places, with zeros entering at the bottom and bits leaving the top lost. The quotient register is unchanged.
- R4: Operation code 01 (single right): the accumulator moves toward its LSB by N places, with its original bit 15 copied into the top N positions. The quotient register is unchanged.
- R5: Operation code 10 (double left): {accumulator, quotient} moves left by N places. Quotient bit 15 feeds accumulator bit 0, zeros enter quotient bit 0, and bits leaving accumulator bit 15 are lost.
- R6: Operation code 11 (double right): {accumulator, quotient} moves right by N places. Accumulator bit 0 feeds quotient bit 15, accumulator bit 15 is replicated into the N vacated top places, and bits leaving quotient bit 0 are lost.
- R7: A count of 0 leaves both registers unchanged and still produces a done pulse.
- R8: Each accepted start produces exactly one done pulse, one cycle wide. In the one-bit-per-clock variant, done is visible after N+2 rising edges counted from the accepting edge inclusive. In the single-cycle variant, done is visible right after the accepting edge.
- R9: A start that arrives while an operation is in progress is ignored.
- R10: The operation code and the count are sampled only at the accepting start. Changes to them afterwards do not alter the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Write both registers from the load ports |
| load_acc | input | 16 | Accumulator load value |
| load_quo | input | 16 | Quotient load value |
| start | input | 1 | Begin a shift |
| op | input | 2 | Operation code: 00 single left, 01 single right, 10 double left, 11 double right |
| count | input | 4 | Shift count N, 0 to 15 |
| done | output | 1 | One-cycle result-valid pulse |
| acc_out | output | 16 | Accumulator read-back |
| quo_out | output | 16 | Quotient read-back |

## Verification
Every operation is run for every count from 0 to 15 with several register patterns, and each pattern separates different faults:
- All zeros and all ones separate zero fill from sign fill.
- A lone bit 15 in both registers exposes a wrong fill source and a missing cross-register transfer in the double modes.
- Random values catch mis-ordered stages.

Separate runs inject noise during the wait. Extra starts, loads and changed operation and count values are driven while an operation is in progress, to show that they are ignored. A same-cycle load and start, and a reset that follows a load, cover the priority and clear paths.

// File: rtl/acq_shift_pkg.sv
package acq_shift_pkg;

   typedef enum logic [1:0] {
      SH_ONE_LEFT  = 2'b00,
      SH_ONE_RIGHT = 2'b01,
      SH_TWO_LEFT  = 2'b10,
      SH_TWO_RIGHT = 2'b11
   } shift_op_e;

   function automatic logic op_is_double(input shift_op_e o);
      return o[1];
   endfunction

   function automatic logic op_is_right(input shift_op_e o);
      return o[0];
   endfunction

endpackage

// File: rtl/acq_shift_core.sv
module acq_shift_core
   import acq_shift_pkg::*;
#(
   parameter int W     = 16,
   parameter int AMT_W = 4
) (
   input  shift_op_e        op_i,
   input  logic [AMT_W-1:0] amt_i,
   input  logic [W-1:0]     acc_i,
   input  logic [W-1:0]     quo_i,
   output logic [W-1:0]     acc_o,
   output logic [W-1:0]     quo_o
);
   localparam int VW = 2 * W;

   logic [VW-1:0] stg [AMT_W+1];
   logic          dbl;
   logic          rgt;
   logic          fill;

   assign dbl    = op_is_double(op_i);
   assign rgt    = op_is_right(op_i);
   // single ops place the accumulator on top with an empty lower half
   assign stg[0] = dbl ? {acc_i, quo_i} : {acc_i, {W{1'b0}}};
   assign fill   = rgt & acc_i[W-1];

   for (genvar s = 0; s < AMT_W; s++) begin : g_stage
      localparam int SH = 1 << s;
      logic [VW-1:0] moved;
      always_comb begin
         if (rgt) moved = {{SH{fill}}, stg[s][VW-1:SH]};
         else     moved = {stg[s][VW-1-SH:0], {SH{1'b0}}};
      end
      assign stg[s+1] = amt_i[s] ? moved : stg[s];
   end

   assign acc_o = stg[AMT_W][VW-1:W];
   assign quo_o = dbl ? stg[AMT_W][W-1:0] : quo_i;

endmodule

// File: rtl/acq_shift_seq.sv
module acq_shift_seq #(
   parameter int CNT_W        = 4,
   parameter bit SINGLE_CYCLE = 1'b0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   input  logic             load,
   input  logic [CNT_W-1:0] cnt_in,
   output logic             accept,
   output logic             busy,
   output logic             step_en,
   output logic             done,
   output logic [CNT_W-1:0] rem
);

   if (SINGLE_CYCLE) begin : g_flat
      assign accept  = start & ~load;
      assign busy    = 1'b0;
      assign step_en = 1'b0;
      assign rem     = '0;
      logic unused_cnt;
      assign unused_cnt = ^cnt_in;
      always_ff @(posedge clk) begin
         if (rst) done <= 1'b0;
         else     done <= accept;
      end
   end else begin : g_iter
      logic             busy_q;
      logic [CNT_W-1:0] rem_q;
      assign accept  = start & ~load & ~busy_q;
      assign busy    = busy_q;
      assign step_en = busy_q & (rem_q != '0);
      assign rem     = rem_q;
      always_ff @(posedge clk) begin
         if (rst) begin
            busy_q <= 1'b0;
            rem_q  <= '0;
            done   <= 1'b0;
         end else begin
            done <= 1'b0;
            if (accept) begin
               busy_q <= 1'b1;
               rem_q  <= cnt_in;
            end else if (step_en) begin
               rem_q <= rem_q - 1'b1;
            end else if (busy_q) begin
               busy_q <= 1'b0;
               done   <= 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/acq_shift_unit.sv
module acq_shift_unit
   import acq_shift_pkg::*;
#(
   parameter int WORD_W       = 16,
   parameter int CNT_W        = 4,
   parameter bit SINGLE_CYCLE = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [WORD_W-1:0] load_acc,
   input  logic [WORD_W-1:0] load_quo,
   input  logic              start,
   input  logic [1:0]        op,
   input  logic [CNT_W-1:0]  count,
   output logic              done,
   output logic [WORD_W-1:0] acc_out,
   output logic [WORD_W-1:0] quo_out
);
   localparam int MAX_SHIFT = (1 << CNT_W) - 1;

   initial begin
      assert (WORD_W >= 2) else $error("WORD_W must be at least 2");
      assert (CNT_W >= 1) else $error("CNT_W must be at least 1");
      assert (MAX_SHIFT < WORD_W) else $error("count range exceeds word width");
   end

   logic              accept;
   logic              busy;
   logic              step_en;
   logic [CNT_W-1:0]  rem;
   shift_op_e         op_q;
   shift_op_e         core_op;
   logic [CNT_W-1:0]  core_amt;
   logic [WORD_W-1:0] acc_r;
   logic [WORD_W-1:0] quo_r;
   logic [WORD_W-1:0] acc_nx;
   logic [WORD_W-1:0] quo_nx;
   logic              commit;

   acq_shift_seq #(
      .CNT_W       (CNT_W),
      .SINGLE_CYCLE(SINGLE_CYCLE)
   ) u_seq (
      .clk    (clk),
      .rst    (rst),
      .start  (start),
      .load   (load),
      .cnt_in (count),
      .accept (accept),
      .busy   (busy),
      .step_en(step_en),
      .done   (done),
      .rem    (rem)
   );

   if (SINGLE_CYCLE) begin : g_amt_full
      assign core_op  = shift_op_e'(op);
      assign core_amt = count;
      assign commit   = accept;
   end else begin : g_amt_unit
      assign core_op  = op_q;
      assign core_amt = CNT_W'(1);
      assign commit   = step_en;
   end

   acq_shift_core #(
      .W    (WORD_W),
      .AMT_W(CNT_W)
   ) u_core (
      .op_i (core_op),
      .amt_i(core_amt),
      .acc_i(acc_r),
      .quo_i(quo_r),
      .acc_o(acc_nx),
      .quo_o(quo_nx)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_r <= '0;
         quo_r <= '0;
         op_q  <= SH_ONE_LEFT;
      end else begin
         if (accept) op_q <= shift_op_e'(op);
         if (load && !busy) begin
            acc_r <= load_acc;
            quo_r <= load_quo;
         end else if (commit) begin
            acc_r <= acc_nx;
            quo_r <= quo_nx;
         end
      end
   end

   assign acc_out = acc_r;
   assign quo_out = quo_r;

endmodule

// File: rtl/acq_shift_checker.sv
module acq_shift_checker #(
   parameter int WORD_W       = 16,
   parameter int CNT_W        = 4,
   parameter bit SINGLE_CYCLE = 1'b0
) (
   input logic              clk,
   input logic              rst,
   input logic              load,
   input logic [WORD_W-1:0] load_acc,
   input logic [WORD_W-1:0] load_quo,
   input logic [CNT_W-1:0]  count,
   input logic              done,
   input logic              accept,
   input logic              busy,
   input logic [CNT_W-1:0]  rem,
   input logic [1:0]        op_q,
   input logic [WORD_W-1:0] acc_r,
   input logic [WORD_W-1:0] quo_r
);
   logic              rst_q = 1'b0;
   logic [WORD_W-1:0] quo_snap = '0;

   always_ff @(posedge clk) begin
      rst_q <= rst;
      if (accept) quo_snap <= quo_r;
   end

   // R1: registers and done are clear after a reset cycle
   p_reset_clear_r1: assert property (@(posedge clk)
      rst_q |-> (acc_r == '0 && quo_r == '0 && !done));

   // R2: an idle load lands in both registers
   p_load_both_r2: assert property (@(posedge clk) disable iff (rst)
      (load && !busy) |=> (acc_r == $past(load_acc) && quo_r == $past(load_quo)));

   // R3 and R4: single-register operations keep the quotient register
   p_quo_hold_r3: assert property (@(posedge clk) disable iff (rst)
      (done && !op_q[1]) |-> (quo_r == quo_snap));

   // R7: a zero count leaves both registers as they were
   p_zero_count_r7: assert property (@(posedge clk) disable iff (rst)
      (accept && count == '0) |=> (acc_r == $past(acc_r) && quo_r == $past(quo_r)));

   // R8: in the stepped variant done never lasts two cycles
   p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
      (done && !SINGLE_CYCLE) |=> !done);

   // R9: a start during an operation does not reload the remaining count
   p_no_restart_r9: assert property (@(posedge clk) disable iff (rst)
      (!SINGLE_CYCLE && busy && rem != '0) |=> (rem == CNT_W'($past(rem) - 1'b1)));

endmodule

bind acq_shift_unit acq_shift_checker #(
   .WORD_W      (WORD_W),
   .CNT_W       (CNT_W),
   .SINGLE_CYCLE(SINGLE_CYCLE)
) u_chk (
   .clk     (clk),
   .rst     (rst),
   .load    (load),
   .load_acc(load_acc),
   .load_quo(load_quo),
   .count   (count),
   .done    (done),
   .accept  (accept),
   .busy    (busy),
   .rem     (rem),
   .op_q    (op_q),
   .acc_r   (acc_r),
   .quo_r   (quo_r)
);

// File: tb/tb_acq_shift_unit.sv
`timescale 1ns/1ps
module tb_acq_shift_unit;
   localparam int W  = 16;
   localparam int CW = 4;
   localparam bit SC = 1'b0;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          load = 1'b0;
   logic [W-1:0]  load_acc = '0;
   logic [W-1:0]  load_quo = '0;
   logic          start = 1'b0;
   logic [1:0]    op = 2'b00;
   logic [CW-1:0] count = '0;
   logic          done;
   logic [W-1:0]  acc_out;
   logic [W-1:0]  quo_out;

   always #10 clk = ~clk;

   acq_shift_unit #(.WORD_W(W), .CNT_W(CW), .SINGLE_CYCLE(SC)) dut (
      .clk(clk), .rst(rst), .load(load), .load_acc(load_acc), .load_quo(load_quo),
      .start(start), .op(op), .count(count), .done(done),
      .acc_out(acc_out), .quo_out(quo_out));

   int     checks = 0;
   int     failures = 0;
   bit     finished = 1'b0;
   string  tag = "R1";

   logic [W-1:0] e_acc = '0, e_quo = '0, r_acc = '0, r_quo = '0;
   logic         e_done = 1'b0;
   bit           m_busy = 1'b0;
   int           m_wait = 0;

   // behavioural reference of the four shifts
   task automatic ref_shift(input logic [1:0] o, input int n,
                            input logic [W-1:0] a, input logic [W-1:0] q,
                            output logic [W-1:0] ra, output logic [W-1:0] rq);
      logic signed [2*W-1:0] v;
      logic signed [W-1:0]   s;
      ra = a; rq = q;
      case (o)
         2'b00: ra = W'(a << n);
         2'b01: begin s = a; ra = W'(s >>> n); end
         2'b10: {ra, rq} = {a, q} << n;
         default: begin v = {a, q}; {ra, rq} = v >>> n; end
      endcase
   endtask

   always @(posedge clk) begin
      if (rst) begin
         e_acc = '0; e_quo = '0; e_done = 1'b0; m_busy = 1'b0; m_wait = 0;
      end else begin
         e_done = 1'b0;
         if (m_busy) begin
            m_wait--;
            if (m_wait == 0) begin
               e_acc = r_acc; e_quo = r_quo; e_done = 1'b1; m_busy = 1'b0;
            end
         end else if (load) begin
            e_acc = load_acc; e_quo = load_quo;
         end else if (start) begin
            ref_shift(op, int'(count), e_acc, e_quo, r_acc, r_quo);
            if (SC) begin
               e_acc = r_acc; e_quo = r_quo; e_done = 1'b1;
            end else begin
               m_wait = int'(count) + 1; m_busy = 1'b1;
            end
         end
      end
   end

   always @(negedge clk) begin
      if (!finished) begin
         checks++;
         if (done !== e_done) begin
            failures++;
            $display("FAIL %s R8 done got %b exp %b", tag, done, e_done);
         end
         if (!m_busy) begin
            checks += 2;
            if (acc_out !== e_acc) begin
               failures++;
               $display("FAIL %s acc got %h exp %h", tag, acc_out, e_acc);
            end
            if (quo_out !== e_quo) begin
               failures++;
               $display("FAIL %s quo got %h exp %h", tag, quo_out, e_quo);
            end
         end
      end
   end

   task automatic do_load(input logic [W-1:0] a, input logic [W-1:0] q);
      load = 1'b1; load_acc = a; load_quo = q;
      @(negedge clk);
      load = 1'b0;
   endtask

   task automatic do_op(input logic [1:0] o, input int n, input bit noise);
      start = 1'b1; op = o; count = CW'(n);
      @(negedge clk);
      start = 1'b0;
      while (m_busy) begin
         if (noise) begin
            start = 1'($urandom); load = 1'($urandom);
            op = 2'($urandom); count = CW'($urandom);
            load_acc = W'($urandom); load_quo = W'($urandom);
         end
         @(negedge clk);
      end
      start = 1'b0; load = 1'b0;
      @(negedge clk);
   endtask

   function automatic string op_tag(input logic [1:0] o, input int n);
      if (n == 0) return "R7";
      case (o)
         2'b00: return "R3";
         2'b01: return "R4";
         2'b10: return "R5";
         default: return "R6";
      endcase
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] pa, pq;
      tag = "R1";
      repeat (3) @(negedge clk);
      rst = 1'b0;
      tag = "R2";
      do_load(16'h1234, 16'hABCD);
      @(negedge clk);
      tag = "R1";
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // full sweep with corner and random values
      for (int o = 0; o < 4; o++) begin
         for (int n = 0; n < 16; n++) begin
            for (int p = 0; p < 5; p++) begin
               case (p)
                  0: begin pa = '0;       pq = '0;       end
                  1: begin pa = '1;       pq = '1;       end
                  2: begin pa = 16'h8000; pq = 16'h8000; end
                  default: begin pa = W'($urandom); pq = W'($urandom); end
               endcase
               tag = "R2";
               do_load(pa, pq);
               tag = op_tag(2'(o), n);
               do_op(2'(o), n, 1'b0);
            end
         end
      end
      // R9 R10: starts, loads and changed inputs during an operation
      for (int k = 0; k < 40; k++) begin
         tag = "R2";
         do_load(W'($urandom), W'($urandom));
         tag = "R9 R10";
         do_op(2'($urandom), int'($urandom_range(1, 15)), 1'b1);
      end
      // R2: load wins over a same-cycle start
      tag = "R2";
      load = 1'b1; start = 1'b1; op = 2'b10; count = 4'd5;
      load_acc = 16'h0F0F; load_quo = 16'hF00D;
      @(negedge clk);
      load = 1'b0; start = 1'b0;
      repeat (20) @(negedge clk);
      // R8: chained operations on the running result
      tag = "R8";
      do_load(16'h8001, 16'h4002);
      do_op(2'b11, 3, 1'b0);
      do_op(2'b10, 7, 1'b0);
      do_op(2'b01, 15, 1'b0);
      repeat (5) @(negedge clk);
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule